// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle Datapath

This block turns the primary opcode and the function field of an instruction word into the control bits that steer a single-cycle datapath. These bits select the register write destination, the ALU second operand, the write-back source, the register and memory write enables, the branch and jump selectors, the immediate extension mode and a two-bit ALU operation code. Seven instructions are recognised: register add, register subtract, OR with immediate, load word, store word, branch-if-equal and jump.

The decoder is purely combinational and has no clock or reset. It is built as two planes. A product plane raises one match line per recognised instruction. A sum plane then ORs the match lines that each control output needs. Any opcode outside the supported set, and any register-format word with an unsupported function code, raises no match line. Every control output then rests at 0, so no register or memory is written and the program counter is not redirected.

Top module: `main_ctrl_decoder`

## Requirements
- R1: An instruction is recognised only from exact encodings. The register-format opcode is 000000, with function 100000 for add and 100010 for sub. The immediate and jump opcodes are ori 001101, lw 100011, sw 101011, beq 000100 and j 000010. The function field is ignored whenever the opcode is not 000000.
- R2: For add, the outputs are reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=1, mem_write=0, npc_sel=0, jump=0 and alu_ctr=00 (ADD).
- R3: For sub, the outputs are the same as for add except that alu_ctr=01 (SUB).
- R4: For ori, the outputs are reg_dst=0, alu_src=1, mem_to_reg=0, reg_write=1, mem_write=0, npc_sel=0, jump=0, ext_op=0 (zero-extend) and alu_ctr=10 (OR).
- R5: For lw, the outputs are reg_dst=0, alu_src=1, mem_to_reg=1, reg_write=1, mem_write=0, npc_sel=0, jump=0, ext_op=1 (sign-extend) and alu_ctr=00.
- R6: For sw, the outputs are alu_src=1, reg_write=0, mem_write=1, npc_sel=0, jump=0, ext_op=1 and alu_ctr=00. reg_dst and mem_to_reg are unspecified.
- R7: For beq, the outputs are alu_src=0, reg_write=0, mem_write=0, npc_sel=1, jump=0 and alu_ctr=01. reg_dst, mem_to_reg and ext_op are unspecified.
- R8: For j, the outputs are jump=1, npc_sel=0, reg_write=0 and mem_write=0. All other outputs are unspecified.
- R9: An unsupported opcode, or opcode 000000 with any function code other than 100000 and 100010, drives reg_write, mem_write, npc_sel and jump to 0.
- R10: The outputs follow the inputs combinationally, and alu_ctr never takes the unused code 11 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, used only for register-format words |
| reg_dst | output | 1 | 1 selects the rd field as write destination, 0 selects rt |
| alu_src | output | 1 | 1 selects the extended immediate as ALU operand B |
| mem_to_reg | output | 1 | 1 writes load data back, 0 writes the ALU result |
| reg_write | output | 1 | Register file write enable |
| mem_write | output | 1 | Data memory write enable |
| npc_sel | output | 1 | Marks a conditional branch for next-PC selection |
| jump | output | 1 | Selects the jump target for the next PC |
| ext_op | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_ctr | output | 2 | ALU operation: 00 ADD, 01 SUB, 10 OR |

## Verification
The bench targets words that lie next to a valid encoding. These include register-format words whose function code is one bit away from add or sub, and immediate opcodes that carry a function field which looks like add or sub. A decoder that ignored the function field would write registers on unsupported R-type words. A decoder that checked the function field on every opcode would treat lw or ori carrying stray low bits as unknown. Every one of the 64 opcodes and every function code under opcode 000000 is also swept, so a stray write enable or branch from a non-instruction would be caught. The sweep also catches an alu_ctr that takes the unused code 11, and ori picking sign extension.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int ALU_W = 2;

  // match-line indices (product plane rows)
  localparam int I_ADD = 0;
  localparam int I_SUB = 1;
  localparam int I_ORI = 2;
  localparam int I_LW  = 3;
  localparam int I_SW  = 4;
  localparam int I_BEQ = 5;
  localparam int I_JMP = 6;
  localparam int N_INSN = 7;

  // control-line indices (sum plane columns)
  localparam int C_ALU0   = 0;
  localparam int C_ALU1   = 1;
  localparam int C_EXT    = 2;
  localparam int C_JUMP   = 3;
  localparam int C_NPC    = 4;
  localparam int C_MEMWR  = 5;
  localparam int C_REGWR  = 6;
  localparam int C_MEM2R  = 7;
  localparam int C_ALUSRC = 8;
  localparam int C_REGDST = 9;
  localparam int N_CTRL   = 10;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [FN_W-1:0] FN_ADD    = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB    = 6'b100010;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  function automatic logic [OP_W-1:0] row_opcode(input int row);
    case (row)
      I_ADD, I_SUB: row_opcode = OPC_RTYPE;
      I_ORI:        row_opcode = OPC_ORI;
      I_LW:         row_opcode = OPC_LW;
      I_SW:         row_opcode = OPC_SW;
      I_BEQ:        row_opcode = OPC_BEQ;
      default:      row_opcode = OPC_JMP;
    endcase
  endfunction

  function automatic logic row_uses_funct(input int row);
    row_uses_funct = (row == I_ADD) || (row == I_SUB);
  endfunction

  function automatic logic [FN_W-1:0] row_funct(input int row);
    row_funct = (row == I_SUB) ? FN_SUB : FN_ADD;
  endfunction

  // sum-plane personality: which match lines feed each control line
  function automatic logic [N_INSN-1:0] col_terms(input int col);
    logic [N_INSN-1:0] t;
    t = '0;
    case (col)
      C_REGDST: begin t[I_ADD] = 1'b1; t[I_SUB] = 1'b1; end
      C_ALUSRC: begin t[I_ORI] = 1'b1; t[I_LW] = 1'b1; t[I_SW] = 1'b1; end
      C_MEM2R:  t[I_LW] = 1'b1;
      C_REGWR:  begin t[I_ADD] = 1'b1; t[I_SUB] = 1'b1;
                      t[I_ORI] = 1'b1; t[I_LW] = 1'b1; end
      C_MEMWR:  t[I_SW] = 1'b1;
      C_NPC:    t[I_BEQ] = 1'b1;
      C_JUMP:   t[I_JMP] = 1'b1;
      C_EXT:    begin t[I_LW] = 1'b1; t[I_SW] = 1'b1; end
      C_ALU0:   begin t[I_SUB] = 1'b1; t[I_BEQ] = 1'b1; end
      C_ALU1:   t[I_ORI] = 1'b1;
      default:  t = '0;
    endcase
    col_terms = t;
  endfunction

endpackage

// File: rtl/mcd_and_plane.sv
module mcd_and_plane
  import mcd_pkg::*;
#(
  parameter int ROWS = N_INSN
) (
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output logic [ROWS-1:0] hit
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic op_eq;
    logic fn_eq;
    assign op_eq = (opcode == row_opcode(r));
    if (row_uses_funct(r)) begin : g_fn
      assign fn_eq = (funct == row_funct(r));
    end else begin : g_nofn
      assign fn_eq = 1'b1;
    end
    assign hit[r] = op_eq & fn_eq;
  end

endmodule

// File: rtl/mcd_or_plane.sv
module mcd_or_plane
  import mcd_pkg::*;
#(
  parameter int ROWS = N_INSN,
  parameter int COLS = N_CTRL
) (
  input  logic [ROWS-1:0] hit,
  output logic [COLS-1:0] ctl
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [ROWS-1:0] TERMS = col_terms(c);
    assign ctl[c] = |(hit & TERMS);
  end

endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
  import mcd_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       reg_dst,
  output logic       alu_src,
  output logic       mem_to_reg,
  output logic       reg_write,
  output logic       mem_write,
  output logic       npc_sel,
  output logic       jump,
  output logic       ext_op,
  output logic [1:0] alu_ctr
);

  logic [N_INSN-1:0] hit;
  logic [N_CTRL-1:0] ctl;

  mcd_and_plane #(.ROWS(N_INSN)) u_and (
    .opcode (opcode),
    .funct  (funct),
    .hit    (hit)
  );

  mcd_or_plane #(.ROWS(N_INSN), .COLS(N_CTRL)) u_or (
    .hit (hit),
    .ctl (ctl)
  );

  assign reg_dst    = ctl[C_REGDST];
  assign alu_src    = ctl[C_ALUSRC];
  assign mem_to_reg = ctl[C_MEM2R];
  assign reg_write  = ctl[C_REGWR];
  assign mem_write  = ctl[C_MEMWR];
  assign npc_sel    = ctl[C_NPC];
  assign jump       = ctl[C_JUMP];
  assign ext_op     = ctl[C_EXT];
  assign alu_ctr    = {ctl[C_ALU1], ctl[C_ALU0]};

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker
  import mcd_pkg::*;
(
  input logic [N_INSN-1:0] hit,
  input logic              alu_src,
  input logic              reg_write,
  input logic              mem_write,
  input logic              npc_sel,
  input logic              jump,
  input logic              ext_op,
  input logic [1:0]        alu_ctr
);

  always_comb begin
    // R1: exact encodings never let two instructions match at once
    p_single_match_r1: assert ($onehot0(hit));
    // R9: no match means nothing is written and flow is untouched
    if (hit == '0)
      p_unknown_quiet_r9: assert (!(reg_write | mem_write | npc_sel | jump));
    // R10: unused ALU code never produced
    p_alu_code_legal_r10: assert (alu_ctr != 2'b11);
    // R8: branch and jump selectors are exclusive
    p_flow_exclusive_r8: assert (!(npc_sel && jump));
    // R6: a store never writes the register file and uses a signed offset
    if (mem_write)
      p_store_shape_r6: assert (!reg_write && ext_op && alu_src);
    // R4: the OR operation always uses a zero-extended immediate
    if (alu_ctr == 2'b10)
      p_or_zero_ext_r4: assert (!ext_op && reg_write && alu_src);
  end

endmodule

bind main_ctrl_decoder mcd_checker u_chk (
  .hit       (hit),
  .alu_src   (alu_src),
  .reg_write (reg_write),
  .mem_write (mem_write),
  .npc_sel   (npc_sel),
  .jump      (jump),
  .ext_op    (ext_op),
  .alu_ctr   (alu_ctr)
);

// File: tb/main_ctrl_decoder_bench.sv
module main_ctrl_decoder_bench;

  // expected/care bit order: [9] reg_dst [8] alu_src [7] mem_to_reg
  // [6] reg_write [5] mem_write [4] npc_sel [3] jump [2] ext_op [1:0] alu_ctr
  typedef struct packed {
    logic [5:0] op;
    logic [5:0] fn;
    logic [9:0] exp;
    logic [9:0] care;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h20, 10'b1001000000, 10'b1111111011, 4'd2},  // R2 add
    '{6'h00, 6'h22, 10'b1001000001, 10'b1111111011, 4'd3},  // R3 sub
    '{6'h0D, 6'h00, 10'b0101000010, 10'b1111111111, 4'd4},  // R4 ori
    '{6'h0D, 6'h22, 10'b0101000010, 10'b1111111111, 4'd1},  // R1 ori, funct ignored
    '{6'h23, 6'h00, 10'b0111000100, 10'b1111111111, 4'd5},  // R5 lw
    '{6'h23, 6'h20, 10'b0111000100, 10'b1111111111, 4'd1},  // R1 lw, funct ignored
    '{6'h2B, 6'h00, 10'b0100100100, 10'b0101111111, 4'd6},  // R6 sw
    '{6'h04, 6'h3F, 10'b0000010001, 10'b0101111011, 4'd7},  // R7 beq
    '{6'h02, 6'h20, 10'b0000001000, 10'b0001111000, 4'd8},  // R8 j
    '{6'h3F, 6'h20, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 unknown op
    '{6'h00, 6'h21, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 near-add funct
    '{6'h00, 6'h23, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 near-sub funct
    '{6'h00, 6'h00, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 funct zero
    '{6'h01, 6'h22, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 op one off
    '{6'h2F, 6'h00, 10'b0000000000, 10'b0001111000, 4'd9},  // R9 near sw
    '{6'h0C, 6'h00, 10'b0000000000, 10'b0001111000, 4'd9}   // R9 near ori
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_write;
  logic npc_sel, jump, ext_op;
  logic [1:0] alu_ctr;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  main_ctrl_decoder u_main_ctrl_decoder (
    .opcode     (opcode),
    .funct      (funct),
    .reg_dst    (reg_dst),
    .alu_src    (alu_src),
    .mem_to_reg (mem_to_reg),
    .reg_write  (reg_write),
    .mem_write  (mem_write),
    .npc_sel    (npc_sel),
    .jump       (jump),
    .ext_op     (ext_op),
    .alu_ctr    (alu_ctr)
  );

  function automatic logic [9:0] packed_out();
    return {reg_dst, alu_src, mem_to_reg, reg_write, mem_write,
            npc_sel, jump, ext_op, alu_ctr};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [9:0] act,
                       input logic [9:0] exp, input logic [9:0] care);
    n_chk++;
    if ((act & care) != (exp & care)) begin
      n_bad++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b care=%b",
               tag, opcode, funct, act, exp, care);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // initial state: all-zero word is an unsupported R-type (R9)
    @(negedge clk);
    check("R9 idle", packed_out(), 10'b0, 10'b0001111000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].fn);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), packed_out(),
            VECS[i].exp, VECS[i].care);
    end

    // R9 sweep: every unsupported opcode with several funct values is quiet
    for (int op = 0; op < 64; op++) begin
      if (op != 6'h00 && op != 6'h0D && op != 6'h23 && op != 6'h2B &&
          op != 6'h04 && op != 6'h02) begin
        for (int fn = 0; fn < 64; fn += 17) begin
          apply(op[5:0], fn[5:0]);
          check("R9 sweep", packed_out(), 10'b0, 10'b0001111000);
        end
      end
    end

    // R1 sweep: under opcode 000000 only 100000/100010 write a register
    for (int fn = 0; fn < 64; fn++) begin
      apply(6'h00, fn[5:0]);
      if (fn == 6'h20 || fn == 6'h22)
        check("R1 rtype", packed_out(), 10'b1001000000, 10'b1111111010);
      else
        check("R1 rtype", packed_out(), 10'b0, 10'b0001111000);
    end

    // R10: full input space, unused ALU code never appears
    for (int w = 0; w < 4096; w++) begin
      apply(w[11:6], w[5:0]);
      check("R10 alu code", {8'b0, (alu_ctr == 2'b11) ? 2'b11 : 2'b00},
            10'b0, 10'b0000000011);
    end

    // R10: combinational response to back-to-back changes (lw then sw)
    apply(6'h23, 6'h00);
    check("R10 lw", packed_out(), 10'b0111000100, 10'b1111111111);
    apply(6'h2B, 6'h00);
    check("R10 sw", packed_out(), 10'b0100100100, 10'b0101111111);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule